// File: doc/BRIEF.md
# Dual-Input PWM Fan Speed Generator

This block turns two unsigned temperature codes into a slow pulse-width-modulated fan drive. Each code is a fraction of full scale: with the default 8-bit width, 255 stands for the supply rail. The larger of the two codes sets the duty cycle. A linear map with a fixed offset and a fixed span turns that code into a threshold. Codes below the window stop the fan, and codes above it run the fan continuously.

A triangle counter sets the time base. It counts up from 0 to its top value and back down, and it moves one step on each cycle in which the `tick` input is high. The output is high while the latched threshold is above the counter. The threshold is latched only at the lower turnaround of the triangle, so a code change never cuts a period short. A one-cycle strobe marks each new period. A supervising controller can hold the output high through a force input, for example while a stalled fan is being started.

Top module: `fan_pwm_gen`

## Requirements
- R1: While reset is held low, and after it is released, `pwm_out` and `period_strobe` are low. The latched threshold starts at zero, so the whole first period is low unless `force_on` is set.
- R2: The counter advances only on cycles with `tick` high. One period has 510 advancing steps (0 up to 255, then 254 down to 1). `period_strobe` is high for exactly one cycle, the cycle in which the counter has just returned to 0.
- R3: If the larger code is 77 or less, the threshold is 0 and the output is low for every cycle of the period.
- R4: If the larger code is 179 or more, the threshold is 256 and the output is high for all 510 cycles of the period.
- R5: For a larger code c from 78 to 178, the threshold is floor((c−77)·256/102). A threshold T from 1 to 255 gives 2·T−1 high cycles in each 510-cycle period. Codes 102, 128 and 153 therefore give 123, 255 and 379 high cycles, which are about 25%, 50% and 75% duty.
- R6: Only the larger of `code_a` and `code_b` controls the duty cycle. Swapping the two codes gives the same duty cycle.
- R7: The threshold is sampled only in the cycle that raises `period_strobe`. A code change in the middle of a period has no effect on that period's high-cycle count.
- R8: While `force_on` is high, `pwm_out` is high in the same cycle, whatever the comparison gives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base enable; the triangle advances one step per high cycle |
| code_a | input | CODE_W | First temperature code, fraction of full scale |
| code_b | input | CODE_W | Second temperature code, fraction of full scale |
| force_on | input | 1 | Forces the output high |
| pwm_out | output | 1 | PWM fan drive |
| period_strobe | output | 1 | One-cycle pulse at the start of each period |

## Verification
If the direction flag or the counter holds a wrong value, the period length changes. The next strobe then arrives early or late, within one period. A wrong latched threshold, or a threshold loaded at the wrong moment, changes the number of high cycles in a period. That error shows up when the period ends. The bench therefore counts high cycles between consecutive strobes and compares the count with the value the mapping predicts. It also changes the codes in the middle of a period to confirm that only the boundary load takes effect.

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen #(
  parameter int CODE_W   = 8,
  parameter int TRI_W    = 8,
  parameter int LO_PCT   = 30,
  parameter int SPAN_PCT = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CODE_W-1:0] code_a,
  input  logic [CODE_W-1:0] code_b,
  input  logic              force_on,
  output logic              pwm_out,
  output logic              period_strobe
);
  localparam int FS    = (1 << CODE_W) - 1;
  localparam int LO    = (FS * LO_PCT + 50) / 100;
  localparam int SPAN  = (FS * SPAN_PCT + 50) / 100;
  localparam int HI    = LO + SPAN;
  localparam int THR_W = TRI_W + 1;
  localparam int PRD_W = CODE_W + TRI_W;

  localparam logic [CODE_W-1:0] LO_C   = CODE_W'(LO);
  localparam logic [CODE_W-1:0] HI_C   = CODE_W'(HI);
  localparam logic [PRD_W-1:0]  SPAN_C = PRD_W'(SPAN);
  localparam logic [THR_W-1:0]  FULL_C = {1'b1, {TRI_W{1'b0}}};
  localparam logic [TRI_W-1:0]  TOP_C  = '1;
  localparam logic [TRI_W-1:0]  ONE_C  = TRI_W'(1);

  logic [CODE_W-1:0] ctrl;
  logic [PRD_W-1:0]  scaled;
  logic [THR_W-1:0]  mapped;
  logic [TRI_W-1:0]  cnt_q;
  logic              down_q;
  logic [THR_W-1:0]  thr_q;
  logic              strobe_q;

  assign ctrl   = (code_a > code_b) ? code_a : code_b;
  assign scaled = {{TRI_W{1'b0}}, ctrl - LO_C} << TRI_W;

  always_comb begin
    if (ctrl <= LO_C)      mapped = '0;
    else if (ctrl >= HI_C) mapped = FULL_C;
    else                   mapped = THR_W'(scaled / SPAN_C);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      down_q   <= 1'b0;
      thr_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= 1'b0;
      if (tick) begin
        if (!down_q) begin
          if (cnt_q == TOP_C) begin
            down_q <= 1'b1;
            cnt_q  <= cnt_q - ONE_C;
          end else begin
            cnt_q <= cnt_q + ONE_C;
          end
        end else if (cnt_q == ONE_C) begin
          cnt_q    <= '0;
          down_q   <= 1'b0;
          strobe_q <= 1'b1;
          thr_q    <= mapped;
        end else begin
          cnt_q <= cnt_q - ONE_C;
        end
      end
    end
  end

  assign pwm_out       = force_on | ({1'b0, cnt_q} < thr_q);
  assign period_strobe = strobe_q;
endmodule

// File: rtl/fan_pwm_gen_chk.sv
module fan_pwm_gen_chk #(
  parameter int CODE_W   = 8,
  parameter int TRI_W    = 8,
  parameter int LO_PCT   = 30,
  parameter int SPAN_PCT = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [CODE_W-1:0] code_a,
  input logic [CODE_W-1:0] code_b,
  input logic              force_on,
  input logic              pwm_out,
  input logic              period_strobe,
  input logic [TRI_W:0]    thr
);
  localparam int FS = (1 << CODE_W) - 1;
  localparam int LO = (FS * LO_PCT + 50) / 100;
  localparam int HI = LO + (FS * SPAN_PCT + 50) / 100;
  localparam logic [CODE_W-1:0] LO_C = CODE_W'(LO);
  localparam logic [CODE_W-1:0] HI_C = CODE_W'(HI);

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    period_strobe |=> !period_strobe); // R2
  AST_STROBE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(period_strobe) |-> $past(tick)); // R2
  AST_THR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !period_strobe |-> $stable(thr)); // R7
  AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    force_on |-> pwm_out); // R8
  AST_LOW_CODES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (period_strobe && !force_on && $past(code_a) <= LO_C && $past(code_b) <= LO_C) |-> !pwm_out); // R3
  AST_HIGH_CODES_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (period_strobe && ($past(code_a) >= HI_C || $past(code_b) >= HI_C)) |-> pwm_out); // R4
endmodule

bind fan_pwm_gen fan_pwm_gen_chk #(
  .CODE_W(CODE_W), .TRI_W(TRI_W), .LO_PCT(LO_PCT), .SPAN_PCT(SPAN_PCT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .code_a(code_a), .code_b(code_b),
  .force_on(force_on), .pwm_out(pwm_out), .period_strobe(period_strobe), .thr(thr_q)
);

// File: tb/fan_pwm_gen_test.sv
module fan_pwm_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int PLEN = 510;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic [7:0] code_a = '0;
  logic [7:0] code_b = '0;
  logic       force_on = 1'b0;
  logic       pwm_out;
  logic       period_strobe;

  int errors = 0;
  int checks = 0;
  int expq[$];
  string tagq[$];
  bit armed = 0;
  int hi_cnt = 0;
  int len_cnt = 0;
  string cur_tag = "";
  int cur_exp = 0;

  fan_pwm_gen uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .code_a(code_a), .code_b(code_b),
    .force_on(force_on), .pwm_out(pwm_out), .period_strobe(period_strobe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_high(input int a, input int b);
    int m;
    int t;
    m = (a > b) ? a : b;
    if (m <= 77)       t = 0;
    else if (m >= 179) t = 256;
    else               t = (m - 77) * 256 / 102;
    if (t == 0)   return 0;
    if (t == 256) return PLEN;
    return 2 * t - 1;
  endfunction

  // monitor: closes a period at every strobe and compares with the queue
  always @(negedge clk) begin
    if (rst_n && period_strobe) begin
      if (armed) begin
        check(hi_cnt == cur_exp, cur_tag, hi_cnt, cur_exp);
        check(len_cnt == PLEN, "R2 period length", len_cnt, PLEN);
      end
      armed = 0;
      if (expq.size() != 0) begin
        cur_exp = expq.pop_front();
        cur_tag = tagq.pop_front();
        armed = 1;
      end
      hi_cnt = 0;
      len_cnt = 0;
    end
    if (armed) begin
      len_cnt++;
      if (pwm_out) hi_cnt++;
    end
  end

  task automatic drive(input int a, input int b, input bit f, input int exp,
                       input string tag, input bit poke);
    @(negedge clk);
    code_a = 8'(a);
    code_b = 8'(b);
    force_on = f;
    @(posedge clk);
    #1;
    expq.push_back(exp);
    tagq.push_back(tag);
    if (poke) begin
      @(negedge clk);
      while (!period_strobe) @(negedge clk);
      repeat (200) @(negedge clk);
      code_a = 8'd255;
      code_b = 8'd0;
    end
    @(negedge clk);
    while (expq.size() != 0 || armed) @(negedge clk);
    force_on = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int gap;
    int width;
    repeat (3) @(negedge clk);
    check(pwm_out == 1'b0, "R1 pwm in reset", pwm_out, 0);
    check(period_strobe == 1'b0, "R1 strobe in reset", period_strobe, 0);
    code_a = 8'd255;
    code_b = 8'd255;
    rst_n = 1'b1;
    repeat (100) @(negedge clk);
    check(pwm_out == 1'b0, "R1 first period low", pwm_out, 0);
    @(negedge clk);
    while (!period_strobe) @(negedge clk);
    code_a = 8'd0;
    code_b = 8'd0;

    drive(0, 0, 0, exp_high(0, 0), "R3 zero codes", 0);
    drive(77, 10, 0, exp_high(77, 10), "R3 at lower edge", 0);
    drive(78, 0, 0, exp_high(78, 0), "R5 just above lower edge", 0);
    drive(102, 0, 0, exp_high(102, 0), "R5 40pct code", 0);
    drive(0, 128, 0, exp_high(0, 128), "R5 50pct code", 0);
    drive(153, 20, 0, exp_high(153, 20), "R5 60pct code", 0);
    drive(178, 0, 0, exp_high(178, 0), "R5 just below upper edge", 0);
    drive(179, 0, 0, exp_high(179, 0), "R4 at upper edge", 0);
    drive(255, 255, 0, exp_high(255, 255), "R4 full scale", 0);
    drive(100, 150, 0, exp_high(100, 150), "R6 b larger", 0);
    drive(150, 100, 0, exp_high(150, 100), "R6 a larger", 0);
    drive(128, 0, 0, exp_high(128, 0), "R7 mid-period change", 1);
    drive(0, 0, 0, exp_high(0, 0), "R3 settle", 0);

    // R8: immediate effect with a zero threshold
    @(negedge clk);
    check(pwm_out == 1'b0, "R8 before force", pwm_out, 0);
    force_on = 1'b1;
    #1;
    check(pwm_out == 1'b1, "R8 force immediate", pwm_out, 1);
    @(negedge clk);
    force_on = 1'b0;
    #1;
    check(pwm_out == 1'b0, "R8 force released", pwm_out, 0);
    drive(0, 0, 1, PLEN, "R8 forced period", 0);

    // R2: gated tick stretches the period by the tick ratio
    @(negedge clk);
    while (!period_strobe) @(negedge clk);
    fork
      begin
        forever begin
          @(negedge clk) tick = 1'b0;
          @(negedge clk) tick = 1'b0;
          @(negedge clk) tick = 1'b1;
        end
      end
      begin
        @(negedge clk);
        while (!period_strobe) @(negedge clk);
        gap = 0;
        width = 0;
        while (period_strobe) begin
          width++;
          @(negedge clk);
        end
        gap = width;
        while (!period_strobe) begin
          gap++;
          @(negedge clk);
        end
      end
    join_any
    disable fork;
    tick = 1'b1;
    check(width == 1, "R2 strobe width", width, 1);
    check(gap == 3 * PLEN, "R2 gated period", gap, 3 * PLEN);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule